// File: doc/BRIEF.md
# Open-Loop CORDIC Rotator for Rotary Position Encoding

This block turns one pair of embedding features (x, y) through a position-dependent angle, which is the core step of rotary position encoding in transformer inference. A new pair and its angle code may enter on any clock cycle. The rotated pair leaves after a fixed number of cycles. A valid bit travels with the data, so gaps in the input stream reappear unchanged at the output.

The angle code does not describe the angle in plain binary. Each bit directly sets the direction of one fixed shift-add micro-rotation, and the top two bits select a quarter turn. Because of this, no stage keeps or compares a residual angle, and the pipeline has no feedback. Every stage is built from arithmetic shifts and adders only, with no multipliers. The hardware sizes below use the default parameters: F = 8 and 12 micro-rotations.

The constant growth in length caused by the micro-rotations is removed by a final shift-add scaling stage. That stage also rounds the result back to the input format and saturates it. A build parameter selects a second variant. In that variant, each pair of neighbouring micro-rotations is folded into one combined shift-add stage, which halves the number of stages and gives the same result.

Top module: `rope_cordic_rotator`

## Requirements
- R1: Inputs and outputs x, y are signed two's complement fixed point with one integer bit and F fractional bits (F+1 bits wide, value = code / 2^F, F = 8 by default and at least 7). The code range is therefore -2^F to 2^F-1.
- R2: The angle code is N+2 bits wide, with N = 12 by default. Bits [N+1:N] hold a quarter-turn count q, giving a rotation of q·90°. Each bit i below N adds +atan(2^-i) when it is 1 and -atan(2^-i) when it is 0. The total angle θ is the sum of these parts.
- R3: Outputs follow a counterclockwise rotation: x' = x·cosθ − y·sinθ and y' = x·sinθ + y·cosθ. Each output lies within 2 LSB of the ideal value after rounding and clamping to the R1 range. This holds for every angle code.
- R4: The CORDIC length growth is cancelled inside the block. For unsaturated results, the output vector length equals the input vector length within 2.5 LSB.
- R5: Results beyond the range saturate and never wrap. An ideal coordinate of 2^F or more gives exactly 2^F−1. An ideal coordinate of −2^F−1 or less gives exactly −2^F. This includes the most negative input code negated by a quarter turn.
- R6: out_valid rises exactly N+2 cycles after the cycle in which in_valid is sampled high. One pair is accepted per cycle, and every gap in in_valid is kept at the output.
- R7: Reset is synchronous and active high. While rst is high, and afterwards for inputs sampled while rst was high, out_valid stays low.
- R8: With the paired-stage variant selected, the results meet the same accuracy as R3. The latency becomes N/2+2 cycles.
- R9: A zero input pair gives exactly zero on both outputs for every angle code.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input pair and angle are present this cycle |
| in_x | input | F+1 | First feature of the pair |
| in_y | input | F+1 | Second feature of the pair |
| in_angle | input | N+2 | Quarter-turn count and micro-rotation direction bits |
| out_valid | output | 1 | Rotated pair is present this cycle |
| out_x | output | F+1 | Rotated first feature |
| out_y | output | F+1 | Rotated second feature |

## Verification
The hardest case to reach from the ports is saturation of the most negative code. It appears only when a full-scale vector lines up with an axis after the quarter turn and the micro-rotations. Random data almost never lands there. The stimulus therefore uses directed angle codes whose micro-rotation directions sum to nearly 0° or 45°. It feeds full-scale and most-negative pairs through every quarter turn. After that, an exhaustive sweep over all angle codes and a random stream with gaps check accuracy and latency against a floating-point rotation. Both the unfolded variant and the paired-stage variant are checked.

// File: rtl/rope_rot_pkg.sv
package rope_rot_pkg;

    // Fractional bits of the external format (seven or more)
    parameter int FRAC_W    = 8;
    // Extra integer bits carried inside the datapath
    parameter int GUARD_INT = 2;
    // Extra fractional bits carried inside the datapath
    parameter int EXT_FRAC  = 6;
    // Number of micro-rotations (even, so stages can be paired)
    parameter int N_MICRO   = 12;

    localparam int DW    = FRAC_W + 1;
    localparam int IW    = GUARD_INT + DW + EXT_FRAC;
    localparam int ANG_W = N_MICRO + 2;

    typedef logic signed [IW-1:0] ival_t;
    typedef logic signed [DW-1:0] oval_t;

    typedef enum logic [1:0] {
        QUAD_0   = 2'd0,
        QUAD_90  = 2'd1,
        QUAD_180 = 2'd2,
        QUAD_270 = 2'd3
    } quad_e;

    typedef struct packed {
        logic                vld;
        ival_t               x;
        ival_t               y;
        logic [N_MICRO-1:0]  dir;
    } rot_beat_t;

    localparam ival_t OUT_MAX = ival_t'((1 << FRAC_W) - 1);
    localparam ival_t OUT_MIN = ival_t'(-(1 << FRAC_W));
    localparam ival_t HALF_LSB = ival_t'(1 << (EXT_FRAC - 1));

    // Sign-extend an external value and align it to the internal fraction
    function automatic ival_t widen(input oval_t v);
        return {{GUARD_INT{v[DW-1]}}, v, {EXT_FRAC{1'b0}}};
    endfunction

    // Multiply by about 0.607239, the inverse of the accumulated CORDIC growth
    function automatic ival_t unit_gain(input ival_t v);
        return (v >>> 1) + (v >>> 3) - (v >>> 6) - (v >>> 9)
             - (v >>> 12) + (v >>> 14);
    endfunction

    // Round to nearest at the external LSB, then clamp to the external range
    function automatic oval_t round_sat(input ival_t v);
        ival_t r;
        r = (v + HALF_LSB) >>> EXT_FRAC;
        if (r > OUT_MAX)
            r = OUT_MAX;
        else if (r < OUT_MIN)
            r = OUT_MIN;
        return oval_t'(r[DW-1:0]);
    endfunction

endpackage

// File: rtl/rope_quadrant_stage.sv
module rope_quadrant_stage
    import rope_rot_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             in_valid,
    input  oval_t            in_x,
    input  oval_t            in_y,
    input  logic [ANG_W-1:0] in_angle,
    output rot_beat_t        q_out
);

    quad_e     quad;
    ival_t     wx;
    ival_t     wy;
    rot_beat_t nxt;

    always_comb begin
        quad    = quad_e'(in_angle[ANG_W-1 -: 2]);
        wx      = widen(in_x);
        wy      = widen(in_y);
        nxt.vld = in_valid;
        nxt.dir = in_angle[N_MICRO-1:0];
        case (quad)
            QUAD_0:   begin nxt.x = wx;  nxt.y = wy;  end
            QUAD_90:  begin nxt.x = -wy; nxt.y = wx;  end
            QUAD_180: begin nxt.x = -wx; nxt.y = -wy; end
            QUAD_270: begin nxt.x = wy;  nxt.y = -wx; end
            default:  begin nxt.x = wx;  nxt.y = wy;  end
        endcase
    end

    always_ff @(posedge clk) begin
        q_out <= nxt;
        if (rst)
            q_out.vld <= 1'b0;
    end

    function automatic longint mag2(input ival_t a, input ival_t b);
        return longint'(a) * longint'(a) + longint'(b) * longint'(b);
    endfunction

    // R2: a quarter turn keeps the squared length exactly
    a_r2_quadrant_keeps_norm: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> (mag2(q_out.x, q_out.y) ==
                      mag2(widen($past(in_x)), widen($past(in_y)))));

endmodule

// File: rtl/rope_micro_stage.sv
module rope_micro_stage
    import rope_rot_pkg::*;
#(
    parameter int IDX    = 0,
    parameter bit MERGED = 1'b0
) (
    input  logic      clk,
    input  logic      rst,
    input  rot_beat_t s_in,
    output rot_beat_t s_out
);

    ival_t nx;
    ival_t ny;

    generate
        if (MERGED) begin : g_pair
            // Two successive micro-rotations folded into one shift-add step
            logic  a_pos;
            logic  b_pos;
            logic  same;
            ival_t x1, x2, xc, y1, y2, yc;
            always_comb begin
                a_pos = s_in.dir[IDX];
                b_pos = s_in.dir[IDX+1];
                same  = (a_pos == b_pos);
                x1 = s_in.x >>> IDX;
                x2 = s_in.x >>> (IDX + 1);
                xc = s_in.x >>> (2 * IDX + 1);
                y1 = s_in.y >>> IDX;
                y2 = s_in.y >>> (IDX + 1);
                yc = s_in.y >>> (2 * IDX + 1);
                nx = s_in.x;
                nx = same  ? nx - xc : nx + xc;
                nx = a_pos ? nx - y1 : nx + y1;
                nx = b_pos ? nx - y2 : nx + y2;
                ny = s_in.y;
                ny = same  ? ny - yc : ny + yc;
                ny = a_pos ? ny + x1 : ny - x1;
                ny = b_pos ? ny + x2 : ny - x2;
            end
        end else begin : g_single
            ival_t sx;
            ival_t sy;
            always_comb begin
                sx = s_in.x >>> IDX;
                sy = s_in.y >>> IDX;
                if (s_in.dir[IDX]) begin
                    nx = s_in.x - sy;
                    ny = s_in.y + sx;
                end else begin
                    nx = s_in.x + sy;
                    ny = s_in.y - sx;
                end
            end
        end
    endgenerate

    always_ff @(posedge clk) begin
        s_out.x   <= nx;
        s_out.y   <= ny;
        s_out.dir <= s_in.dir;
        if (rst)
            s_out.vld <= 1'b0;
        else
            s_out.vld <= s_in.vld;
    end

    // R9: a zero vector stays zero through every shift-add step
    a_r9_zero_stays_zero: assert property (@(posedge clk) disable iff (rst)
        (s_in.x == '0 && s_in.y == '0) |=> (s_out.x == '0 && s_out.y == '0));

endmodule

// File: rtl/rope_gain_sat.sv
module rope_gain_sat
    import rope_rot_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  in_vld,
    input  ival_t in_x,
    input  ival_t in_y,
    output logic  out_valid,
    output oval_t out_x,
    output oval_t out_y
);

    ival_t gx;
    ival_t gy;

    always_comb begin
        gx = unit_gain(in_x);
        gy = unit_gain(in_y);
    end

    always_ff @(posedge clk) begin
        out_x <= round_sat(gx);
        out_y <= round_sat(gy);
        if (rst)
            out_valid <= 1'b0;
        else
            out_valid <= in_vld;
    end

    // R5: saturation never flips the sign of the scaled result
    a_r5_no_wrap_pos: assert property (@(posedge clk) disable iff (rst)
        (!gx[IW-1] && !gy[IW-1]) |=> (!out_x[DW-1] && !out_y[DW-1]));
    a_r5_no_wrap_neg: assert property (@(posedge clk) disable iff (rst)
        (gx[IW-1] && gy[IW-1]) |=> ($signed(out_x) <= 0 && $signed(out_y) <= 0));

endmodule

// File: rtl/rope_cordic_rotator.sv
module rope_cordic_rotator
    import rope_rot_pkg::*;
#(
    parameter bit MERGE_PAIRS = 1'b0
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     in_valid,
    input  logic signed [DW-1:0]     in_x,
    input  logic signed [DW-1:0]     in_y,
    input  logic        [ANG_W-1:0]  in_angle,
    output logic                     out_valid,
    output logic signed [DW-1:0]     out_x,
    output logic signed [DW-1:0]     out_y
);

    localparam int STEP  = MERGE_PAIRS ? 2 : 1;
    localparam int N_STG = N_MICRO / STEP;
    localparam int LAT   = N_STG + 2;
    localparam int CNT_W = $clog2(LAT + 1) + 1;

    rot_beat_t chain [N_STG+1];

    rope_quadrant_stage u_quad (
        .clk      (clk),
        .rst      (rst),
        .in_valid (in_valid),
        .in_x     (in_x),
        .in_y     (in_y),
        .in_angle (in_angle),
        .q_out    (chain[0])
    );

    generate
        for (genvar g = 0; g < N_STG; g++) begin : g_stage
            rope_micro_stage #(
                .IDX    (g * STEP),
                .MERGED (MERGE_PAIRS)
            ) u_micro (
                .clk   (clk),
                .rst   (rst),
                .s_in  (chain[g]),
                .s_out (chain[g+1])
            );
        end
    endgenerate

    rope_gain_sat u_gain (
        .clk       (clk),
        .rst       (rst),
        .in_vld    (chain[N_STG].vld),
        .in_x      (chain[N_STG].x),
        .in_y      (chain[N_STG].y),
        .out_valid (out_valid),
        .out_x     (out_x),
        .out_y     (out_y)
    );

    // Checker state: pairs accepted but not yet delivered
    logic [CNT_W-1:0] inflight;

    always_ff @(posedge clk) begin
        if (rst)
            inflight <= '0;
        else
            inflight <= inflight + CNT_W'(in_valid) - CNT_W'(out_valid);
    end

    // R6: every output beat has an accepted input behind it
    a_r6_valid_has_source: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> (inflight != '0));
    // R6: the pipeline never holds more beats than its depth
    a_r6_bounded_depth: assert property (@(posedge clk) disable iff (rst)
        inflight <= CNT_W'(LAT));

endmodule

// File: tb/test_rope_cordic_rotator.sv
module test_rope_cordic_rotator;
    import rope_rot_pkg::*;

    localparam int   LAT_B      = N_MICRO + 2;
    localparam int   LAT_M      = N_MICRO / 2 + 2;
    localparam int   CODE_MAX   = (1 << FRAC_W) - 1;
    localparam int   CODE_MIN   = -(1 << FRAC_W);
    localparam int   MICRO_MASK = (1 << N_MICRO) - 1;
    localparam int   TOL        = 2;
    localparam real  PI         = 3.14159265358979;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic in_valid = 1'b0;
    logic signed [DW-1:0] in_x = '0;
    logic signed [DW-1:0] in_y = '0;
    logic [ANG_W-1:0] in_angle = '0;

    logic ov_b, ov_m;
    logic signed [DW-1:0] ox_b, oy_b, ox_m, oy_m;

    int cyc = 0;
    int n_chk = 0;
    int n_fail = 0;

    typedef struct { int x; int y; int ang; int due; } item_t;
    item_t pend [2][$];

    always #10 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    rope_cordic_rotator #(.MERGE_PAIRS(1'b0)) i_rope_cordic_rotator (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_x(in_x), .in_y(in_y),
        .in_angle(in_angle), .out_valid(ov_b), .out_x(ox_b), .out_y(oy_b));

    rope_cordic_rotator #(.MERGE_PAIRS(1'b1)) i_rope_cordic_rotator_pair (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_x(in_x), .in_y(in_y),
        .in_angle(in_angle), .out_valid(ov_m), .out_x(ox_m), .out_y(oy_m));

    task automatic note(input bit ok, input string req, input string what,
                        input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d (cycle %0d)",
                     req, what, act, exp, cyc);
        end
    endtask

    task automatic finish_up();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    function automatic int iabs(input int v);
        return (v < 0) ? -v : v;
    endfunction

    // R2: angle from quarter count plus signed arctangent terms
    function automatic real ang_rad(input int code);
        real th;
        th = real'((code >> N_MICRO) & 3) * (PI / 2.0);
        for (int i = 0; i < N_MICRO; i++) begin
            if (((code >> i) & 1) == 1) th = th + $atan(2.0 ** (-i));
            else                        th = th - $atan(2.0 ** (-i));
        end
        return th;
    endfunction

    function automatic int rnd_sat(input real v);
        real f;
        f = $floor(v + 0.5);
        if (f > real'(CODE_MAX)) return CODE_MAX;
        if (f < real'(CODE_MIN)) return CODE_MIN;
        return $rtoi(f);
    endfunction

    task automatic judge(input int lane, input item_t it, input int ox, input int oy);
        real th, xr, yr, mi, mo;
        int ex, ey;
        string rq;
        rq = (lane == 1) ? "R8" : "R3";
        th = ang_rad(it.ang);
        xr = real'(it.x) * $cos(th) - real'(it.y) * $sin(th);
        yr = real'(it.x) * $sin(th) + real'(it.y) * $cos(th);
        ex = rnd_sat(xr);
        ey = rnd_sat(yr);
        note(iabs(ox - ex) <= TOL, rq, "x accuracy", ox, ex);
        note(iabs(oy - ey) <= TOL, rq, "y accuracy", oy, ey);
        if (xr >= real'(CODE_MAX + 1)) note(ox == CODE_MAX, "R5", "x high clamp", ox, CODE_MAX);
        if (xr <= real'(CODE_MIN - 1)) note(ox == CODE_MIN, "R5", "x low clamp", ox, CODE_MIN);
        if (yr >= real'(CODE_MAX + 1)) note(oy == CODE_MAX, "R5", "y high clamp", oy, CODE_MAX);
        if (yr <= real'(CODE_MIN - 1)) note(oy == CODE_MIN, "R5", "y low clamp", oy, CODE_MIN);
        if (it.x == 0 && it.y == 0) begin
            note(ox == 0, "R9", "zero x", ox, 0);
            note(oy == 0, "R9", "zero y", oy, 0);
        end
        mi = $sqrt(real'(it.x * it.x + it.y * it.y));
        if (mi <= 250.0) begin
            mo = $sqrt(real'(ox * ox + oy * oy));
            note((mo - mi <= 2.5) && (mi - mo <= 2.5), "R4", "length",
                 $rtoi(mo), $rtoi(mi));
        end
    endtask

    task automatic score(input int lane, input logic v, input int ox, input int oy);
        item_t it;
        if (v) begin
            if (pend[lane].size() == 0 || pend[lane][0].due != cyc) begin
                note(1'b0, "R6", "unexpected out_valid", 1, 0);
            end else begin
                it = pend[lane].pop_front();
                note(1'b1, "R6", "latency", cyc, it.due);
                judge(lane, it, ox, oy);
            end
        end else if (pend[lane].size() != 0 && pend[lane][0].due == cyc) begin
            note(1'b0, "R6", "missing out_valid", 0, 1);
            void'(pend[lane].pop_front());
        end
    endtask

    always @(negedge clk) begin
        if (!rst) begin
            score(0, ov_b, int'(ox_b), int'(oy_b));
            score(1, ov_m, int'(ox_m), int'(oy_m));
        end
    end

    task automatic push(input int x, input int y, input int ang);
        @(negedge clk);
        in_valid = 1'b1;
        in_x     = x[DW-1:0];
        in_y     = y[DW-1:0];
        in_angle = ang[ANG_W-1:0];
        pend[0].push_back('{x, y, ang, cyc + LAT_B});
        pend[1].push_back('{x, y, ang, cyc + LAT_M});
    endtask

    task automatic idle(input int n);
        repeat (n) begin
            @(negedge clk);
            in_valid = 1'b0;
        end
    endtask

    function automatic int rnd_code();
        return int'($urandom_range(0, CODE_MAX - CODE_MIN)) + CODE_MIN;
    endfunction

    // Micro codes whose direction sums are near 45 and near 0 degrees
    localparam int NEAR45 = 12'h57D;
    localparam int NEAR0  = 12'h8D1;

    initial begin
        void'($urandom(32'd20240611));
        // R7: reset holds the outputs idle even with input beats offered
        rst = 1'b1;
        repeat (5) begin
            @(negedge clk);
            in_valid = 1'b1;
            in_x = DW'(rnd_code());
            in_y = DW'(rnd_code());
            note(ov_b == 1'b0, "R7", "out_valid in reset (binary)", int'(ov_b), 0);
            note(ov_m == 1'b0, "R7", "out_valid in reset (paired)", int'(ov_m), 0);
        end
        @(negedge clk);
        rst = 1'b0;
        in_valid = 1'b0;
        repeat (LAT_B + 2) begin
            @(negedge clk);
            note(!ov_b && !ov_m, "R7", "beats offered in reset leak out",
                 int'(ov_b) + int'(ov_m), 0);
        end

        // R9: zero pairs
        push(0, 0, 0);
        push(0, 0, (3 << N_MICRO) | (NEAR45 & MICRO_MASK));
        push(0, 0, MICRO_MASK);
        // R5: full-scale pairs turned onto an axis
        push(CODE_MAX, CODE_MAX, NEAR45 & MICRO_MASK);
        push(CODE_MIN, CODE_MIN, NEAR45 & MICRO_MASK);
        push(CODE_MIN, CODE_MAX, (1 << N_MICRO) | (NEAR45 & MICRO_MASK));
        // R5 / R1: most negative code through every quarter turn
        for (int q = 0; q < 4; q++) begin
            push(CODE_MIN, 0, (q << N_MICRO) | (NEAR0 & MICRO_MASK));
            push(0, CODE_MIN, (q << N_MICRO) | (NEAR0 & MICRO_MASK));
            push(CODE_MIN, CODE_MIN, (q << N_MICRO) | (NEAR0 & MICRO_MASK));
        end
        // R2: extreme direction patterns
        push(CODE_MAX, 0, MICRO_MASK);
        push(CODE_MAX, 0, 0);
        push(100, -50, (2 << N_MICRO) | 1);
        idle(3);

        // R3 / R8: every angle code, back to back
        for (int a = 0; a < (1 << ANG_W); a++)
            push(rnd_code(), rnd_code(), a);

        // R6: random stream with gaps
        for (int k = 0; k < 3000; k++) begin
            if ($urandom_range(0, 3) == 0) idle(int'($urandom_range(1, 3)));
            push(rnd_code(), rnd_code(), int'($urandom_range(0, (1 << ANG_W) - 1)));
        end
        idle(LAT_B + 4);
        note(pend[0].size() == 0, "R6", "binary beats left undelivered", pend[0].size(), 0);
        note(pend[1].size() == 0, "R8", "paired beats left undelivered", pend[1].size(), 0);
        finish_up();
    end

    initial begin
        #(20 * 150000);
        note(1'b0, "R6", "watchdog expired", cyc, 0);
        finish_up();
    end

endmodule